// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation converter that has a sample phase. A falling edge on the active-low start input, accepted only while the active-low select is low, begins a conversion. The sequencer takes a snapshot of the channel configuration and drives it to the analog multiplexer. It then holds the sample switches closed for an acquire window. After that it presents one trial code per clock to the DAC, from the most significant bit down to the least significant bit. For each trial it keeps or drops the bit according to a one-bit comparator input.

When the last bit has been decided, the block writes the result and the 4-bit channel tag into one output word. It then releases the active-low busy output, so a rising busy edge marks valid data. A conversion that is under way cannot be restarted. The acquire length is set in nanoseconds and converted to clock cycles from the clock period parameter.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion is accepted only when the start input was high before a clock edge and is low at that edge while the select input is low. busy_n falls on that same edge. A start low with select high, or a start held low with no falling edge, leaves busy_n high.
- R2: The result register is cleared when a conversion is accepted. The first trial code is exactly the MSB alone, regardless of the previous result, and dac_code is zero during the acquire window.
- R3: While busy_n is low, further start edges and changes on the configuration inputs have no effect on the conversion timing, the result or the channel tag.
- R4: Trials run one per clock from bit RES-1 down to bit 0. The trial code for bit k is the bits already decided above k, with bit k set and all lower bits clear.
- R5: A trial bit is kept when cmp_in is high at the clock edge that ends that trial's cycle, which means the input is at or above the trial level. With an ideal comparator, the result equals the input level.
- R6: busy_n stays low for exactly ACQ + RES + 1 cycles. It rises on the same edge that loads the output word.
- R7: The output word holds the differential flag in bit RES+3, the 3-bit address in bits RES+2..RES and the result in bits RES-1..0.
- R8: sample_en is high for exactly ACQ = max(1, ceil(ACQ_MIN_NS / CLK_NS)) cycles, starting at the accepting edge, and is low during the trials.
- R9: mux_diff and mux_addr take the configuration inputs on the edge where busy_n falls, and they hold that value until the next accepted conversion.
- R10: After a synchronous reset, busy_n is high, and sample_en, dac_code, out_word and the mux outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; must be low for a start to be accepted |
| convst_n | input | 1 | Active-low conversion start; acts on its falling edge |
| cmp_in | input | 1 | Comparator result, high when the input is at or above the trial level |
| cfg_diff | input | 1 | Differential flag for the next conversion |
| cfg_addr | input | 3 | Multiplexer address for the next conversion |
| busy_n | output | 1 | Low while a conversion is in progress |
| sample_en | output | 1 | Sample switch strobe, high during the acquire window |
| dac_code | output | RES | Trial code presented to the DAC |
| mux_diff | output | 1 | Differential flag driven to the multiplexer |
| mux_addr | output | 3 | Address driven to the multiplexer |
| out_word | output | RES+4 | Output word: channel tag and result |

## Verification
The bench builds the block with RES = 8, CLK_NS = 50 and ACQ_MIN_NS = 150, which gives a three-cycle acquire window. With these values every one of the 256 input levels can be converted, through an ideal comparator modelled in the bench. The same sweep checks every trial code along each search path, the exact busy and sample window lengths, and all 16 channel tags. Further conversions toggle the start input and the configuration inputs in the middle of a conversion, and separate cases try starts with the select input high and with no falling edge.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ACQ   = 2'd1,
        PH_TRIAL = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic       diff;
        logic [2:0] addr;
    } chan_cfg_t;

    localparam int TAG_W = $bits(chan_cfg_t);

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/sarc_start_det.sv
module sarc_start_det (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic convst_n,
    output logic start_req
);
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) conv_q <= 1'b1;
        else     conv_q <= convst_n;
    end

    assign start_req = conv_q & ~convst_n & ~cs_n;

endmodule

// File: rtl/sarc_phase_ctl.sv
module sarc_phase_ctl
    import sarc_pkg::*;
#(
    parameter int RES = 12,
    parameter int ACQ = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_req,
    output phase_e                   phase,
    output logic [$clog2(RES)-1:0]   bit_idx,
    output logic                     busy_n,
    output logic                     accept,
    output logic                     trial_en,
    output logic                     load
);
    localparam int IDX_W = $clog2(RES);
    localparam int CNT_W = $clog2(ACQ + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACQ - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES - 1);

    logic [CNT_W-1:0] acq_cnt;

    assign accept   = (phase == PH_IDLE) && start_req;
    assign trial_en = (phase == PH_TRIAL);
    assign load     = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            acq_cnt <= '0;
            bit_idx <= '0;
            busy_n  <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_req) begin
                        phase   <= PH_ACQ;
                        acq_cnt <= '0;
                        busy_n  <= 1'b0;
                    end
                end
                PH_ACQ: begin
                    if (acq_cnt == CNT_LAST) begin
                        phase   <= PH_TRIAL;
                        bit_idx <= IDX_TOP;
                    end else begin
                        acq_cnt <= acq_cnt + 1'b1;
                    end
                end
                PH_TRIAL: begin
                    if (bit_idx == '0) phase <= PH_DONE;
                    else               bit_idx <= bit_idx - 1'b1;
                end
                PH_DONE: begin
                    phase  <= PH_IDLE;
                    busy_n <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: a conversion under way keeps busy low until its final phase
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACQ || phase == PH_TRIAL) |=> !busy_n);

    // R4: trial index steps down by one per clock
    a_r4_msb_down: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL && $past(phase) == PH_TRIAL) |->
        (IDX_W'(bit_idx + 1'b1) == $past(bit_idx)));

    // R8: trials begin only after a full acquire window
    a_r8_acq_len: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL && $past(phase) == PH_ACQ) |->
        ($past(acq_cnt) == CNT_LAST));

endmodule

// File: rtl/sarc_sar_reg.sv
module sarc_sar_reg #(
    parameter int RES = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   trial_en,
    input  logic [$clog2(RES)-1:0] bit_idx,
    input  logic                   cmp_in,
    output logic [RES-1:0]         sar,
    output logic [RES-1:0]         dac_code
);
    logic [RES-1:0] trial_bit;

    assign trial_bit = RES'(1) << bit_idx;
    assign dac_code  = trial_en ? (sar | trial_bit) : sar;

    always_ff @(posedge clk) begin
        if (rst)           sar <= '0;
        else if (clear)    sar <= '0;
        else if (trial_en) sar[bit_idx] <= cmp_in;
    end

    // R4: a trial code adds exactly one bit on top of the decided bits
    a_r4_one_trial_bit: assert property (@(posedge clk) disable iff (rst)
        trial_en |-> ($countones(dac_code ^ sar) == 1));

endmodule

// File: rtl/sarc_out_latch.sv
module sarc_out_latch
    import sarc_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  chan_cfg_t            tag,
    input  logic [RES-1:0]       result,
    output logic [RES+TAG_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)       word <= '0;
        else if (load) word <= {tag, result};
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sarc_pkg::*;
#(
    parameter int RES        = 12,
    parameter int CLK_NS     = 25,
    parameter int ACQ_MIN_NS = 150
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           convst_n,
    input  logic           cmp_in,
    input  logic           cfg_diff,
    input  logic [2:0]     cfg_addr,
    output logic           busy_n,
    output logic           sample_en,
    output logic [RES-1:0] dac_code,
    output logic           mux_diff,
    output logic [2:0]     mux_addr,
    output logic [RES+3:0] out_word
);
    localparam int ACQ   = at_least_one(ceil_div(ACQ_MIN_NS, CLK_NS));
    localparam int IDX_W = $clog2(RES);

    logic             start_req;
    logic             accept;
    logic             trial_en;
    logic             load;
    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    logic [RES-1:0]   sar;
    chan_cfg_t        mux_cfg;

    sarc_start_det u_start (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .convst_n  (convst_n),
        .start_req (start_req)
    );

    sarc_phase_ctl #(.RES(RES), .ACQ(ACQ)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .busy_n    (busy_n),
        .accept    (accept),
        .trial_en  (trial_en),
        .load      (load)
    );

    sarc_sar_reg #(.RES(RES)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .trial_en (trial_en),
        .bit_idx  (bit_idx),
        .cmp_in   (cmp_in),
        .sar      (sar),
        .dac_code (dac_code)
    );

    always_ff @(posedge clk) begin
        if (rst)         mux_cfg <= '0;
        else if (accept) mux_cfg <= '{diff: cfg_diff, addr: cfg_addr};
    end

    sarc_out_latch #(.RES(RES)) u_out (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .tag    (mux_cfg),
        .result (sar),
        .word   (out_word)
    );

    assign sample_en = (phase == PH_ACQ);
    assign mux_diff  = mux_cfg.diff;
    assign mux_addr  = mux_cfg.addr;

    // R1: busy falls only after a qualified start
    a_r1_start_qualified: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> $past(!cs_n && !convst_n));

    // R2: result register is empty at conversion start
    a_r2_sar_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> (sar == '0));

    // R6: busy rises together with the result word
    a_r6_word_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (out_word[RES-1:0] == $past(sar)));

    // R9: multiplexer configuration holds while busy
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && $past(!busy_n)) |-> $stable(mux_cfg));

endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RES        = 8;
    localparam int CLK_NS     = 50;
    localparam int ACQ_MIN_NS = 150;
    localparam int ACQ        = (ACQ_MIN_NS + CLK_NS - 1) / CLK_NS;

    logic           clk = 1'b0;
    logic           rst;
    logic           cs_n;
    logic           convst_n;
    logic           cmp_in;
    logic           cfg_diff;
    logic [2:0]     cfg_addr;
    logic           busy_n;
    logic           sample_en;
    logic [RES-1:0] dac_code;
    logic           mux_diff;
    logic [2:0]     mux_addr;
    logic [RES+3:0] out_word;

    int  vin = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ideal comparator: input at or above trial level
    assign cmp_in = (vin >= int'(dac_code));

    sar_seq_ctrl #(.RES(RES), .CLK_NS(CLK_NS), .ACQ_MIN_NS(ACQ_MIN_NS)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .convst_n  (convst_n),
        .cmp_in    (cmp_in),
        .cfg_diff  (cfg_diff),
        .cfg_addr  (cfg_addr),
        .busy_n    (busy_n),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .mux_diff  (mux_diff),
        .mux_addr  (mux_addr),
        .out_word  (out_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_conv(input int v, input bit d, input int a, input bit glitch);
        int tag;
        int low_cnt;
        tag = (int'(d) << 3) | (a & 7);
        vin = v;
        cfg_diff = d;
        cfg_addr = 3'(a);
        convst_n = 1'b0;
        @(negedge clk);
        low_cnt = 0;
        chk(busy_n == 1'b0, "R1 busy falls on start", int'(busy_n), 0);
        chk({mux_diff, mux_addr} == 4'(tag), "R9 mux takes cfg", int'({mux_diff, mux_addr}), tag);
        convst_n = 1'b1;
        if (glitch) begin
            cfg_diff = ~d;
            cfg_addr = ~3'(a);
        end
        for (int j = 0; j < ACQ; j++) begin
            chk(sample_en == 1'b1, "R8 acquire window", int'(sample_en), 1);
            chk(dac_code == '0, "R2 code zero in acquire", int'(dac_code), 0);
            if (!busy_n) low_cnt++;
            if (glitch) convst_n = j[0];
            @(negedge clk);
        end
        for (int k = RES - 1; k >= 0; k--) begin
            int exp_code;
            exp_code = (v & ~((1 << (k + 1)) - 1)) | (1 << k);
            chk(int'(dac_code) == exp_code, "R4 trial code", int'(dac_code), exp_code);
            if (k == RES - 1)
                chk(int'(dac_code) == (1 << (RES - 1)), "R2 first trial MSB only",
                    int'(dac_code), 1 << (RES - 1));
            chk(sample_en == 1'b0, "R8 no sample in trials", int'(sample_en), 0);
            if (!busy_n) low_cnt++;
            if (glitch) convst_n = ~convst_n;
            @(negedge clk);
        end
        if (!busy_n) low_cnt++;
        convst_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R6 busy released", int'(busy_n), 1);
        chk(low_cnt == ACQ + RES + 1, "R6 busy length", low_cnt, ACQ + RES + 1);
        chk(int'(out_word[RES-1:0]) == v, "R5 result equals input",
            int'(out_word[RES-1:0]), v);
        chk(int'(out_word) == ((tag << RES) | v), "R7 word layout",
            int'(out_word), (tag << RES) | v);
        if (glitch)
            chk({mux_diff, mux_addr} == 4'(tag), "R3 cfg change ignored",
                int'({mux_diff, mux_addr}), tag);
        cfg_diff = d;
        cfg_addr = 3'(a);
        @(negedge clk);
        chk(busy_n == 1'b1, "R3 no spurious restart", int'(busy_n), 1);
    endtask

    initial begin
        rst = 1'b1;
        cs_n = 1'b1;
        convst_n = 1'b1;
        cfg_diff = 1'b0;
        cfg_addr = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy_n == 1'b1, "R10 busy_n", int'(busy_n), 1);
        chk(sample_en == 1'b0, "R10 sample_en", int'(sample_en), 0);
        chk(dac_code == '0, "R10 dac_code", int'(dac_code), 0);
        chk(out_word == '0, "R10 out_word", int'(out_word), 0);
        chk({mux_diff, mux_addr} == 4'd0, "R10 mux", int'({mux_diff, mux_addr}), 0);

        // R1: select high blocks the start
        convst_n = 1'b0;
        @(negedge clk);
        chk(busy_n == 1'b1, "R1 select high ignored", int'(busy_n), 1);
        // R1: select goes low with start held low: no edge, no start
        cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(busy_n == 1'b1, "R1 no edge no start", int'(busy_n), 1);
        chk(sample_en == 1'b0, "R1 no acquire", int'(sample_en), 0);
        convst_n = 1'b1;
        @(negedge clk);

        // R5 sweep over every level, rotating through all channel tags
        for (int v = 0; v < (1 << RES); v++)
            run_conv(v, v[3], (v * 5) & 7, 1'b0);

        // R2: high result then low input
        run_conv((1 << RES) - 1, 1'b1, 7, 1'b0);
        run_conv(0, 1'b0, 0, 1'b0);

        // R3: start toggles and config changes during conversions
        run_conv(8'h5a, 1'b1, 2, 1'b1);
        run_conv(8'ha5, 1'b0, 5, 1'b1);
        run_conv((1 << RES) - 1, 1'b1, 6, 1'b1);
        run_conv(1, 1'b0, 1, 1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule